// File: doc/BRIEF.md
# Slot-Reserving Memory Request Scheduler

This block sits on the processor side of a memory channel where the memory side handles its own device timing, refresh and precharge. The scheduler never issues device commands. Its only job is to decide when each read's data will come back on the shared data bus. Bus time is divided into slots, and one slot is the time the bus needs to carry one cache line. The scheduler keeps a reservation map covering a window of future slots. It uses a fixed memory latency, measured in slots and set by parameter, which the memory side advertises.

When a request is accepted, the scheduler searches the map starting a full memory latency ahead of the current slot. It claims the first open slot it finds as the primary slot. It then claims the next open slot after that one as a backup. On the following cycle it issues the request tag together with both slot indices, so that the returning data can be matched to the request. When a slot closes, the scheduler looks at whether data was present in it:

- If data arrived in a primary slot, the backup reservation is released.
- If a primary slot closed empty, the backup is kept and the data is expected there instead.
- If a backup slot that is still held also closes empty, an error is flagged.

The request input is a valid/ready stream. `req_ready` depends only on the state of the map, never on `req_valid`, and a request is taken on any edge where both are high. The issue output has no back-pressure. It is a one-cycle pulse for each accepted request.

Top module: `slot_sched`

## Requirements
- R1: After reset, every slot is free, `slot_now` is 0, `req_ready` is 1, and both `iss_valid` and `miss_err` are 0.
- R2: `slot_last` is high on the last cycle of every SLOT_CYC-cycle slot period. On the edge that ends that cycle, `slot_now` advances by one, wrapping modulo NSLOT. At every other time it holds.
- R3: The primary slot is the first unreserved slot whose distance ahead of `slot_now`, measured in the accept cycle, is at least ML_SLOTS. Closer slots are never chosen.
- R4: The backup slot is the first unreserved slot after the primary slot. Its distance ahead of `slot_now` must be at most NSLOT-1.
- R5: One cycle after each accepted request, `iss_valid` pulses with that request's tag, primary index and backup index. Issues come out in the order the requests were accepted, and there is at most one per cycle.
- R6: `req_ready` is low exactly when no primary-and-backup pair fits inside the window. A request offered while ready is low is held off and is not lost.
- R7: A reservation ends when its slot closes, and that slot index becomes free for later searches.
- R8: If `ret_hit` is high on the closing cycle of a primary slot, the paired backup slot is freed at once.
- R9: `ret_hit` is sampled only on the `slot_last` cycle. If a backup slot that is still held closes with `ret_hit` low, `miss_err` pulses for one cycle on the next cycle. If `ret_hit` is high at that point, no error is raised.
- R10: `ret_hit` while an unreserved slot closes has no effect on any reservation or on `miss_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | A primary and backup pair is available |
| req_tag | input | TAG_W | Request identifier |
| iss_valid | output | 1 | Issue pulse, one cycle after accept |
| iss_tag | output | TAG_W | Tag of the issued request |
| iss_pri | output | log2(NSLOT) | Primary slot index |
| iss_bak | output | log2(NSLOT) | Backup slot index |
| slot_now | output | log2(NSLOT) | Index of the current slot |
| slot_last | output | 1 | Last cycle of the current slot |
| ret_hit | input | 1 | Data present in the slot now closing |
| miss_err | output | 1 | A held backup slot closed with no data |

## Verification
The hardest state to reach is a nearly full window. In that state a backup freed by a primary hit, or a slot that has just closed, decides whether `req_ready` rises again and which index the next request receives. The stimulus reaches it by offering a request on every cycle for well over a window's worth of cycles, which is faster than slots retire. Meanwhile the return pattern, chosen from the tag, delivers data in some primaries, leaves others empty with a filled backup, and leaves some with both slots empty. The bench keeps its own reservation map, so every ready level and every assigned index is compared while the window fills, stalls and drains, including after `slot_now` has wrapped.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  typedef enum logic [1:0] {
    ROLE_NONE = 2'd0,
    ROLE_PRI  = 2'd1,
    ROLE_BAK  = 2'd2
  } role_t;
endpackage

// File: rtl/slot_clock.sv
module slot_clock #(
  parameter int SLOT_CYC = 4,
  parameter int IDX_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] cur,
  output logic             last
);
  localparam int CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

  logic [CW-1:0] cyc;

  assign last = (cyc == CW'(SLOT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= '0;
      cur <= '0;
    end else if (last) begin
      cyc <= '0;
      cur <= cur + 1'b1;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  // R2
  slot_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> cur == IDX_W'($past(cur) + 1'b1));
  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(cur));
endmodule

// File: rtl/slot_finder.sv
module slot_finder #(
  parameter int NSLOT    = 64,
  parameter int IDX_W    = 6,
  parameter int ML_SLOTS = 4
) (
  input  logic [NSLOT-1:0] res,
  input  logic [IDX_W-1:0] cur,
  output logic             pri_ok,
  output logic             bak_ok,
  output logic [IDX_W-1:0] pri_idx,
  output logic [IDX_W-1:0] bak_idx
);
  logic [NSLOT-1:0] rel;
  logic [IDX_W-1:0] pri_off;
  logic [IDX_W-1:0] bak_off;

  for (genvar g = 0; g < NSLOT; g++) begin : g_rot
    assign rel[g] = res[cur + IDX_W'(g)];
  end

  always_comb begin
    pri_off = '0;
    pri_ok  = 1'b0;
    for (int i = NSLOT - 1; i >= ML_SLOTS; i--) begin
      if (!rel[i]) begin
        pri_off = IDX_W'(i);
        pri_ok  = 1'b1;
      end
    end
  end

  always_comb begin
    bak_off = '0;
    bak_ok  = 1'b0;
    for (int i = NSLOT - 1; i > 0; i--) begin
      if (pri_ok && !rel[i] && (IDX_W'(i) > pri_off)) begin
        bak_off = IDX_W'(i);
        bak_ok  = 1'b1;
      end
    end
  end

  assign pri_idx = cur + pri_off;
  assign bak_idx = cur + bak_off;
endmodule

// File: rtl/slot_ring.sv
module slot_ring
  import slot_sched_pkg::*;
#(
  parameter int NSLOT = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cur,
  input  logic             last,
  input  logic             ret_hit,
  input  logic             take,
  input  logic [IDX_W-1:0] pri_idx,
  input  logic [IDX_W-1:0] bak_idx,
  output logic [NSLOT-1:0] res,
  output logic             miss_err
);
  role_t            role [NSLOT];
  logic [IDX_W-1:0] link [NSLOT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res      <= '0;
      miss_err <= 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
        role[i] <= ROLE_NONE;
        link[i] <= '0;
      end
    end else begin
      miss_err <= 1'b0;
      if (last) begin
        if (role[cur] == ROLE_PRI && ret_hit) begin
          res[link[cur]]  <= 1'b0;
          role[link[cur]] <= ROLE_NONE;
        end
        if (role[cur] == ROLE_BAK && !ret_hit) miss_err <= 1'b1;
        res[cur]  <= 1'b0;
        role[cur] <= ROLE_NONE;
      end
      if (take) begin
        res[pri_idx]  <= 1'b1;
        res[bak_idx]  <= 1'b1;
        role[pri_idx] <= ROLE_PRI;
        role[bak_idx] <= ROLE_BAK;
        link[pri_idx] <= bak_idx;
      end
    end
  end

  // R4
  take_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (!res[pri_idx] && !res[bak_idx] && pri_idx != bak_idx));
  // R9
  miss_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_err |-> $past(last));
  // R7
  expire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !take) |=> !res[$past(cur)]);
endmodule

// File: rtl/slot_sched.sv
module slot_sched #(
  parameter int NSLOT    = 64,
  parameter int SLOT_CYC = 4,
  parameter int ML_SLOTS = 4,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TAG_W-1:0] req_tag,
  output logic             iss_valid,
  output logic [TAG_W-1:0] iss_tag,
  output logic [IDX_W-1:0] iss_pri,
  output logic [IDX_W-1:0] iss_bak,
  output logic [IDX_W-1:0] slot_now,
  output logic             slot_last,
  input  logic             ret_hit,
  output logic             miss_err
);
  logic [NSLOT-1:0] res;
  logic             pri_ok, bak_ok, take;
  logic [IDX_W-1:0] pri_idx, bak_idx;

  slot_clock #(.SLOT_CYC(SLOT_CYC), .IDX_W(IDX_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .cur(slot_now), .last(slot_last)
  );

  slot_finder #(.NSLOT(NSLOT), .IDX_W(IDX_W), .ML_SLOTS(ML_SLOTS)) u_find (
    .res(res), .cur(slot_now), .pri_ok(pri_ok), .bak_ok(bak_ok),
    .pri_idx(pri_idx), .bak_idx(bak_idx)
  );

  assign req_ready = pri_ok && bak_ok;
  assign take      = req_valid && req_ready;

  slot_ring #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .cur(slot_now), .last(slot_last),
    .ret_hit(ret_hit), .take(take), .pri_idx(pri_idx), .bak_idx(bak_idx),
    .res(res), .miss_err(miss_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_valid <= 1'b0;
      iss_tag   <= '0;
      iss_pri   <= '0;
      iss_bak   <= '0;
    end else begin
      iss_valid <= take;
      if (take) begin
        iss_tag <= req_tag;
        iss_pri <= pri_idx;
        iss_bak <= bak_idx;
      end
    end
  end

  // R3
  start_dist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> IDX_W'(pri_idx - slot_now) >= IDX_W'(ML_SLOTS));
  // R4
  bak_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> IDX_W'(bak_idx - slot_now) > IDX_W'(pri_idx - slot_now));
  // R5
  issue_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (iss_valid && iss_tag == $past(req_tag)));
  // R5
  issue_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !iss_valid);
endmodule

// File: tb/sim_slot_sched.sv
module sim_slot_sched;
  localparam int NS = 64, IW = 6, SC = 4, ML = 4, TW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_ready, iss_valid, slot_last, ret_hit, miss_err;
  logic [TW-1:0] req_tag, iss_tag;
  logic [IW-1:0] iss_pri, iss_bak, slot_now;

  slot_sched #(.NSLOT(NS), .SLOT_CYC(SC), .ML_SLOTS(ML), .TAG_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_tag(req_tag), .iss_valid(iss_valid), .iss_tag(iss_tag),
    .iss_pri(iss_pri), .iss_bak(iss_bak), .slot_now(slot_now),
    .slot_last(slot_last), .ret_hit(ret_hit), .miss_err(miss_err)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  int q_tag[$], q_pri[$], q_bak[$];
  int mres[NS], mrole[NS], mlink[NS], mtag[NS];
  int mcur = 0, mcyc = 0, mode = 1;
  bit err_exp = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void search(output bit ok, output int p, output int b);
    int po = -1, bo = -1;
    for (int o = ML; o < NS; o++)
      if (po < 0 && mres[(mcur + o) % NS] == 0) po = o;
    if (po >= 0)
      for (int o = po + 1; o < NS; o++)
        if (bo < 0 && mres[(mcur + o) % NS] == 0) bo = o;
    ok = (po >= 0) && (bo >= 0);
    p  = (mcur + po) % NS;
    b  = (mcur + bo) % NS;
  endfunction

  // driver: one cycle of stimulus and model, pushes expected issues
  task automatic step(input bit want, input int tag);
    bit ok, hit, last;
    int p, b, s;
    search(ok, p, b);
    last = (mcyc == SC - 1);
    chk(int'(slot_now) == mcur, "R2 slot_now", int'(slot_now), mcur);
    chk(slot_last == last, "R2 slot_last", int'(slot_last), int'(last));
    // R6 R7 R8 R10: ready level follows the model map
    chk(req_ready == ok, "R6 req_ready", int'(req_ready), int'(ok));
    chk(miss_err == err_exp, "R9 miss_err", int'(miss_err), int'(err_exp));
    err_exp = 1'b0;
    s = mcur;
    hit = 1'b0;
    if (mode == 1) begin
      if (mrole[s] == 1)      hit = (mtag[s] % 2) == 0;
      else if (mrole[s] == 2) hit = ((mtag[s] / 2) % 2) == 0;
      else                    hit = (mcur % 2) == 0;  // R10 stray data
    end
    req_valid = want;
    req_tag   = TW'(tag);
    ret_hit   = hit;
    if (want && ok) begin
      q_tag.push_back(tag); q_pri.push_back(p); q_bak.push_back(b);
      mres[p] = 1; mres[b] = 1; mrole[p] = 1; mrole[b] = 2;
      mlink[p] = b; mtag[p] = tag; mtag[b] = tag;
    end
    if (last) begin
      if (mrole[s] == 1 && hit) begin  // R8
        mres[mlink[s]] = 0; mrole[mlink[s]] = 0;
      end
      if (mrole[s] == 2 && !hit) err_exp = 1'b1;  // R9
      mres[s] = 0; mrole[s] = 0;  // R7
      mcur = (mcur + 1) % NS;
      mcyc = 0;
    end else begin
      mcyc++;
    end
    @(negedge clk);
  endtask

  // monitor: pops expected issues as the design produces them
  always @(negedge clk) begin
    int t, p, b;
    if (rst_n === 1'b1 && !done && iss_valid) begin
      if (q_tag.size() == 0) begin
        chk(1'b0, "R5 unexpected issue", 1, 0);
      end else begin
        t = q_tag.pop_front(); p = q_pri.pop_front(); b = q_bak.pop_front();
        chk(int'(iss_tag) == t, "R5 iss_tag", int'(iss_tag), t);
        chk(int'(iss_pri) == p, "R3 iss_pri", int'(iss_pri), p);
        chk(int'(iss_bak) == b, "R4 iss_bak", int'(iss_bak), b);
      end
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_tag = '0; ret_hit = 1'b0;
    for (int i = 0; i < NS; i++) begin
      mres[i] = 0; mrole[i] = 0; mlink[i] = 0; mtag[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    chk(iss_valid == 1'b0, "R1 iss_valid", int'(iss_valid), 0);
    chk(miss_err == 1'b0, "R1 miss_err", int'(miss_err), 0);
    chk(slot_now == '0, "R1 slot_now", int'(slot_now), 0);
    rst_n = 1'b1;
    // single request on an empty map
    step(1'b1, 0);
    repeat (10) step(1'b0, 0);
    // saturating burst: fill, stall, reuse freed slots
    for (int i = 0; i < 120; i++) step(1'b1, i % 16);
    repeat (300) step(1'b0, 0);
    // sparse traffic after slot_now has wrapped
    for (int i = 0; i < 240; i++) step((i % 3) == 0, i % 16);
    repeat (300) step(1'b0, 0);
    // no data at all: the backup must raise the error (R9)
    mode = 0;
    step(1'b1, 5);
    repeat (60) step(1'b0, 0);
    chk(q_tag.size() == 0, "R5 pending issues", q_tag.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule